// File: doc/BRIEF.md
# Serial Control Port with Interrupt Latching

This block is the host-facing register port of a line interface device. A host selects it with an active-low select, clocks in an eight-bit command byte least significant bit first, and then either shifts in one control byte or shifts out one status byte. The control byte sets the line-length code, two loopback modes and an all-ones transmit select. It also holds one clear/mask bit for each of two monitored conditions: loss of signal and driver fault.

The port watches the two condition inputs, synchronises them and latches any change of level. While a latch is set, the active-low interrupt is driven. Writing 1 to a clear bit empties that latch and blocks further latching until 0 is written back. The status byte carries the live condition levels, the line-length code, and a 3-bit field. That field reports change events first, then remote loopback, then local loopback and all-ones transmit.

All serial pins are sampled by the block's system clock through synchronisers. Input bits are taken on the rising serial clock. Output bits change on the falling serial clock. The data output is presented as a value plus an output enable, so the pad can share one wire with the data input.

Top module: `serctl_port`

## Requirements
- R1: Command byte bit 0 (first in) selects the operation, 1 = read and 0 = write. Bits 1 to 6 are the address, with bit 1 as its least significant bit. Bit 7 is ignored.
- R2: Only address 16 is answered. For any other address the output enable stays low for the whole frame, and write data changes nothing.
- R3: Write data is the eight bits after the command byte, LSB first. Bit 0 is clear-LOS and bit 1 is clear-DPM. Bits 2, 3 and 4 are remote loopback, local loopback and all-ones transmit. Bits 5 to 7 are line-length bits 0 to 2. The control outputs follow within a few clocks of the last data bit.
- R4: Read data bit 0 is the live LOS level, bit 1 the live DPM level, and bits 2 to 4 the line-length code. The output enable is high from the first falling serial clock after the command byte until the falling clock after D7, and low otherwise.
- R5: Read bits 5, 6, 7 form a code. If either change latch is set: bit 5 = 1, bit 6 = LOS latch, bit 7 = DPM latch. Else if remote loopback is on: 1,0,0. Otherwise: 0, local loopback, all-ones transmit.
- R6: A change of either synchronised level latches that source's flag when its clear bit is 0. The interrupt output is low while any flag is set.
- R7: Writing 1 to a clear bit empties that flag and blocks it from latching while the bit stays 1. A clear write beats a change in the same cycle.
- R8: Writing 0 to a clear bit re-enables latching, including a change in the same cycle as that write. Reading the status never empties a flag.
- R9: Deasserting the select resets the bit count and drops the output enable. An aborted write changes nothing.
- R10: After reset, all control outputs are 0, the interrupt is high, the output enable is low, and a read returns code 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_din | input | 1 | Serial data in, LSB first |
| los_in | input | 1 | Loss-of-signal level, asynchronous |
| dpm_in | input | 1 | Driver fault level, asynchronous |
| ser_dout | output | 1 | Serial read data value |
| ser_dout_oe | output | 1 | Drive enable for the serial data pad |
| irq_n | output | 1 | Active-low interrupt |
| loop_remote | output | 1 | Remote loopback select |
| loop_local | output | 1 | Local loopback select |
| tx_ones | output | 1 | All-ones transmit select |
| line_len | output | 3 | Line-length code |

## Verification
A write that commits a clear bit can land in the same system clock as a detected change on the same condition input. The bench provokes this by toggling the condition input one clock after the last rising serial clock of a write frame, which aligns the two synchronised paths. It judges the outcome at the interrupt pin and in a following status read. With the clear bit at 1, the flag must be empty. With the clear bit at 0, the flag must be set, even when the bit was 1 before the write.

// File: rtl/serctl_pkg.sv
// Shared types for the serial control port.
// Assumes the control byte layout below is the one decoded by the line logic.
package serctl_pkg;

    // Control byte as written by the host; field order is MSB to LSB.
    typedef struct packed {
        logic [2:0] len;       // bits 7..5 : line-length code
        logic       ones;      // bit 4     : all-ones transmit
        logic       lloop;     // bit 3     : local loopback
        logic       rloop;     // bit 2     : remote loopback
        logic       mask_dpm;  // bit 1     : clear/mask driver fault
        logic       mask_los;  // bit 0     : clear/mask loss of signal
    } ctrl_t;

endpackage

// File: rtl/scp_sync.sv
// Multi-bit level synchroniser: a chain of STAGES flops per bit.
// Assumes each bit is an independent slow level; no bus coherence is implied.
module scp_sync #(
    parameter int unsigned    W       = 1,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
// Serial frame engine: captures the command byte, shifts in write data or
// shifts out a status snapshot.
// Assumes select, serial clock and data are already synchronised to clk.
// Input bits are taken on serial-clock rise, output bits change on its fall.
module scp_shifter #(
    parameter int unsigned        ADDR_W   = 6,
    parameter int unsigned        BYTE_W   = 8,
    parameter logic [ADDR_W-1:0]  DEV_ADDR = ADDR_W'(16)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [BYTE_W-1:0] status_i,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              dout,
    output logic              dout_oe
);
    localparam int unsigned HDR_W   = ADDR_W + 1;      // rw bit + address
    localparam int unsigned CMD_W   = ADDR_W + 2;      // plus ignored bit
    localparam int unsigned FRAME_W = CMD_W + BYTE_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_W);

    logic              sclk_q;
    logic [CNT_W-1:0]  cnt;
    logic [HDR_W-1:0]  hdr;
    logic [BYTE_W-1:0] wsh;
    logic [BYTE_W-1:0] snap;
    logic              rise, fall, addr_hit, rd_hit;

    assign rise     = sclk_s & ~sclk_q;
    assign fall     = ~sclk_s & sclk_q;
    assign addr_hit = (hdr[HDR_W-1:1] == DEV_ADDR);
    assign rd_hit   = hdr[0] & addr_hit;

    // Delay the serial clock one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Count bits, capture header and write data, and commit a write at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            hdr     <= '0;
            wsh     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (sel_n_s) begin
                cnt <= '0;
            end else if (rise && cnt != CNT_END) begin
                cnt <= cnt + 1'b1;
                if (cnt < CNT_HDR)
                    hdr <= {sdi_s, hdr[HDR_W-1:1]};
                else if (cnt >= CNT_CMD)
                    wsh <= {sdi_s, wsh[BYTE_W-1:1]};
                if (cnt == CNT_LAST && !hdr[0] && addr_hit) begin
                    wr_en   <= 1'b1;
                    wr_data <= {sdi_s, wsh[BYTE_W-1:1]};
                end
            end
        end
    end

    // Drive read bits on falling edges; the status is snapshot at the first one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
            snap    <= '0;
        end else if (sel_n_s) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (fall) begin
            if (rd_hit && cnt >= CNT_CMD && cnt != CNT_END) begin
                dout_oe <= 1'b1;
                if (cnt == CNT_CMD) begin
                    dout <= status_i[0];
                    snap <= status_i >> 1;
                end else begin
                    dout <= snap[0];
                    snap <= snap >> 1;
                end
            end else begin
                dout    <= 1'b0;
                dout_oe <= 1'b0;
            end
        end
    end

    // R9: a deselect drops the pad enable on the next clock.
    a_r9_deselect_releases: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> !dout_oe);
    // R9: a deselect restarts the bit count.
    a_r9_deselect_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> (cnt == '0));
    // R4: the pad is only driven once the command byte is complete.
    a_r4_oe_after_command: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (cnt >= CNT_CMD));
    // R3: a write commits only with the full frame counted.
    a_r3_write_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cnt == CNT_END));
endmodule

// File: rtl/scp_regs.sv
// Control register, change latches, interrupt and status encoder.
// Assumes the LOS and DPM levels arrive synchronised to clk and that wr_en
// pulses for one cycle per accepted write.
module scp_regs
    import serctl_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              los_s,
    input  logic              dpm_s,
    output ctrl_t             ctrl,
    output logic [BYTE_W-1:0] status,
    output logic              irq_n
);
    logic los_d, dpm_d, los_chg, dpm_chg;
    logic los_edge, dpm_edge, mask_los_eff, mask_dpm_eff;
    logic clr_los, clr_dpm;
    logic [2:0] code;   // code[0] is status bit 5

    assign los_edge     = los_s ^ los_d;
    assign dpm_edge     = dpm_s ^ dpm_d;
    assign clr_los      = wr_en & wr_data[0];
    assign clr_dpm      = wr_en & wr_data[1];
    assign mask_los_eff = wr_en ? wr_data[0] : ctrl.mask_los;
    assign mask_dpm_eff = wr_en ? wr_data[1] : ctrl.mask_dpm;

    // Load the control byte on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl <= '0;
        else if (wr_en) ctrl <= ctrl_t'(wr_data);
    end

    // Keep the previous levels for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            los_d <= 1'b0;
            dpm_d <= 1'b0;
        end else begin
            los_d <= los_s;
            dpm_d <= dpm_s;
        end
    end

    // Latch changes; a clear write wins over a change in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            los_chg <= 1'b0;
            dpm_chg <= 1'b0;
        end else begin
            if (clr_los)                        los_chg <= 1'b0;
            else if (los_edge && !mask_los_eff) los_chg <= 1'b1;
            if (clr_dpm)                        dpm_chg <= 1'b0;
            else if (dpm_edge && !mask_dpm_eff) dpm_chg <= 1'b1;
        end
    end

    // Encode the status byte: change events before loopback reporting.
    always_comb begin
        if (los_chg || dpm_chg) code = {dpm_chg, los_chg, 1'b1};
        else if (ctrl.rloop)    code = 3'b001;
        else                    code = {ctrl.ones, ctrl.lloop, 1'b0};
        status = {code, ctrl.len, dpm_s, los_s};
    end

    assign irq_n = ~(los_chg | dpm_chg);

    // R7: a clear write empties the flag.
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_los |=> !los_chg);
    // R7: a set mask blocks new latching.
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mask_dpm && !wr_en) |=> !$rose(dpm_chg));
    // R8: without a clear write a flag stays set.
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (los_chg && !clr_los) |=> los_chg);
    // R3: the control byte only moves on a write.
    a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));
    // R6: a flag only rises after a level change.
    a_r6_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_chg) |-> $past(los_edge));
endmodule

// File: rtl/serctl_port.sv
// Serial control port top: synchronisers, frame engine and register block.
// Assumes the serial clock runs well below clk/4 so every edge is seen.
module serctl_port
    import serctl_pkg::*;
#(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter int unsigned       ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = ADDR_W'(16)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n,
    input  logic       ser_clk,
    input  logic       ser_din,
    input  logic       los_in,
    input  logic       dpm_in,
    output logic       ser_dout,
    output logic       ser_dout_oe,
    output logic       irq_n,
    output logic       loop_remote,
    output logic       loop_local,
    output logic       tx_ones,
    output logic [2:0] line_len
);
    localparam int unsigned BYTE_W = $bits(ctrl_t);

    logic [2:0]        ser_s;
    logic [1:0]        cond_s;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, status;
    ctrl_t             ctrl;

    scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_ser_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sel_n, ser_clk, ser_din}), .dout(ser_s));

    scp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_cond_sync (
        .clk(clk), .rst_n(rst_n),
        .din({dpm_in, los_in}), .dout(cond_s));

    scp_shifter #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DEV_ADDR(DEV_ADDR)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sel_n_s(ser_s[2]), .sclk_s(ser_s[1]), .sdi_s(ser_s[0]),
        .status_i(status), .wr_en(wr_en), .wr_data(wr_data),
        .dout(ser_dout), .dout_oe(ser_dout_oe));

    scp_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .los_s(cond_s[0]), .dpm_s(cond_s[1]),
        .ctrl(ctrl), .status(status), .irq_n(irq_n));

    assign loop_remote = ctrl.rloop;
    assign loop_local  = ctrl.lloop;
    assign tx_ones     = ctrl.ones;
    assign line_len    = ctrl.len;
endmodule

// File: tb/serctl_port_tb.sv
module serctl_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
    logic los_in = 1'b0, dpm_in = 1'b0;
    logic ser_dout, ser_dout_oe, irq_n, loop_remote, loop_local, tx_ones;
    logic [2:0] line_len;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // model state
    logic [7:0] m_ctrl = 8'h00;
    logic m_los = 0, m_dpm = 0, m_lc = 0, m_dc = 0;

    always #10 clk = ~clk;   // 50 MHz

    serctl_port u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .los_in(los_in), .dpm_in(dpm_in),
        .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe), .irq_n(irq_n),
        .loop_remote(loop_remote), .loop_local(loop_local),
        .tx_ones(tx_ones), .line_len(line_len));

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [2:0] c;
        if (m_lc || m_dc)   c = {m_dc, m_lc, 1'b1};
        else if (m_ctrl[2]) c = 3'b001;
        else                c = {m_ctrl[4], m_ctrl[3], 1'b0};
        return {c, m_ctrl[7:5], m_dpm, m_los};
    endfunction

    function automatic logic [7:0] mk_cmd(input logic rd, input logic [5:0] a, input logic b7);
        return {b7, a, rd};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbits; tog: 0 none, 1 LOS, 2 DPM toggled in line with the commit.
    task automatic frame(input logic [7:0] cmd, input logic [7:0] wd, input int nbits,
                         input int tog, output logic [7:0] rd, output logic oe_bad);
        logic oe_exp;
        oe_exp = cmd[0] && (cmd[6:1] == 6'd16) && (nbits == 16);
        rd = 8'h00;
        oe_bad = 0;
        @(negedge clk);
        sel_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 8) ? cmd[i] : wd[i-8];
            wait_clk(6);
            if (i >= 8) begin
                rd[i-8] = ser_dout;
                if (ser_dout_oe !== oe_exp) oe_bad = 1;
            end else if (ser_dout_oe !== 1'b0) oe_bad = 1;
            ser_clk = 1'b1;
            if (tog != 0 && i == 15) begin
                wait_clk(1);
                if (tog == 1) los_in = ~los_in; else dpm_in = ~dpm_in;
                wait_clk(5);
            end else wait_clk(6);
            ser_clk = 1'b0;
        end
        wait_clk(6);
        if (ser_dout_oe !== 1'b0) oe_bad = 1;
        sel_n = 1'b1;
        ser_din = 1'b0;
        wait_clk(6);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] wd, input logic b7,
                            input int tog, input string req);
        logic [7:0] rd;
        logic bad;
        frame(mk_cmd(1'b0, a, b7), wd, 16, tog, rd, bad);
        if (tog == 1) m_los = ~m_los;
        if (tog == 2) m_dpm = ~m_dpm;
        if (a == 6'd16) begin
            m_ctrl = wd;
            if (wd[0]) m_lc = 0; else if (tog == 1) m_lc = 1;
            if (wd[1]) m_dc = 0; else if (tog == 2) m_dc = 1;
        end else begin
            if (tog == 1 && !m_ctrl[0]) m_lc = 1;
            if (tog == 2 && !m_ctrl[1]) m_dc = 1;
        end
        wait_clk(4);
        check(req, "oe during write frame", {31'd0, bad}, 32'd0);
    endtask

    task automatic do_read(input logic [5:0] a, input logic b7, input string req);
        logic [7:0] rd;
        logic bad;
        logic [7:0] e;
        e = exp_status();
        frame(mk_cmd(1'b1, a, b7), 8'h00, 16, 0, rd, bad);
        check(req, "oe window on read", {31'd0, bad}, 32'd0);
        if (a == 6'd16) check(req, "read byte", {24'd0, rd}, {24'd0, e});
    endtask

    task automatic toggle(input int which);
        @(negedge clk);
        if (which == 1) begin
            los_in = ~los_in; m_los = ~m_los;
            if (!m_ctrl[0]) m_lc = 1;
        end else begin
            dpm_in = ~dpm_in; m_dpm = ~m_dpm;
            if (!m_ctrl[1]) m_dc = 1;
        end
        wait_clk(8);
    endtask

    task automatic check_pins(input string req);
        check(req, "irq_n", {31'd0, irq_n}, {31'd0, ~(m_lc | m_dc)});
        check(req, "control outputs", {26'd0, line_len, tx_ones, loop_local, loop_remote},
              {26'd0, m_ctrl[7:2]});
        check(req, "oe idle", {31'd0, ser_dout_oe}, 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        // R10: reset state
        check_pins("R10");
        do_read(6'd16, 1'b0, "R10");

        // R3/R5: mode reporting
        do_write(6'd16, 8'b000_10000, 1'b0, 0, "R3");   // all-ones
        check_pins("R3"); do_read(6'd16, 1'b0, "R5");
        do_write(6'd16, 8'b101_01000, 1'b0, 0, "R3");   // local loop, len 5
        check_pins("R3"); do_read(6'd16, 1'b0, "R5");
        do_write(6'd16, 8'b011_11000, 1'b0, 0, "R5");   // ones + local
        do_read(6'd16, 1'b0, "R5");
        do_write(6'd16, 8'b110_11100, 1'b1, 0, "R1");   // remote wins, bit 7 of command set
        check_pins("R1"); do_read(6'd16, 1'b1, "R5");

        // R6/R8: change latching, read does not clear
        toggle(1);
        check_pins("R6");
        do_read(6'd16, 1'b0, "R6");
        do_read(6'd16, 1'b0, "R8");
        check_pins("R8");
        toggle(2);
        do_read(6'd16, 1'b0, "R5");
        // R7: clear and mask
        do_write(6'd16, 8'b000_00011, 1'b0, 0, "R7");
        check_pins("R7");
        toggle(1); toggle(2);
        check_pins("R7");
        do_read(6'd16, 1'b0, "R7");
        // R8: re-enable
        do_write(6'd16, 8'b000_00000, 1'b0, 0, "R8");
        toggle(2);
        check_pins("R8");
        do_read(6'd16, 1'b0, "R8");

        // R7: clear coincides with change -> clear wins
        do_write(6'd16, 8'b000_00011, 1'b0, 1, "R7");
        check_pins("R7");
        do_read(6'd16, 1'b0, "R7");
        // R8: re-enable write coincides with change -> latched
        do_write(6'd16, 8'b000_00010, 1'b0, 1, "R8");
        check_pins("R8");
        do_read(6'd16, 1'b0, "R8");
        do_write(6'd16, 8'b000_00011, 1'b0, 0, "R7");

        // R2: other addresses
        do_write(6'd17, 8'hFC, 1'b0, 0, "R2");
        check_pins("R2");
        do_read(6'd0, 1'b0, "R2");
        do_read(6'd48, 1'b1, "R2");

        // R9: aborted write then full write
        begin
            logic [7:0] rd;
            logic bad;
            frame(mk_cmd(1'b0, 6'd16, 1'b0), 8'hFC, 12, 0, rd, bad);
            wait_clk(4);
            check_pins("R9");
            frame(mk_cmd(1'b1, 6'd16, 1'b0), 8'h00, 11, 0, rd, bad);
            check("R9", "oe after aborted read", {31'd0, ser_dout_oe}, 32'd0);
        end
        do_write(6'd16, 8'b010_00100, 1'b0, 0, "R9");
        check_pins("R9");

        // random mix
        for (int k = 0; k < 70; k++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0, 1: do_write(6'd16, 8'($urandom()), 1'($urandom()),
                               (op == 1) ? int'($urandom_range(0, 2)) : 0, "R3");
                2:    do_read(6'd16, 1'($urandom()), "R4");
                3:    toggle(int'($urandom_range(1, 2)));
                4:    begin
                          logic [5:0] a;
                          a = 6'($urandom());
                          if (a == 6'd16) a = 6'd15;
                          if ($urandom_range(0, 1) == 1) do_read(a, 1'b0, "R2");
                          else do_write(a, 8'($urandom()), 1'b0, 0, "R2");
                      end
                default: do_read(6'd16, 1'b0, "R5");
            endcase
            check_pins("R6");
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule